// File: doc/BRIEF.md
# Command-Word Bus Master

This block turns a stream of 34-bit command words into single accesses on a pipelined Wishbone bus. The upper two bits of each word say what to do. The lower 32 bits carry the data, the address or the control code. A word is taken when its strobe is high and the busy flag is low. Busy stays high for as long as a bus cycle is open.

Each bus access opens a cycle of its own. CYC and STB rise together, and STB falls once the slave stops stalling. CYC falls on the acknowledge or on a bus error, so CYC always drops between two accesses. The address register can be loaded with an absolute value or moved by a signed-free (modular) offset. It can also be set to step by one after every request the slave accepts.

A bus-reset word is taken even while busy, and it abandons any open cycle. Every event sends back one 34-bit response word with a one-cycle strobe: write acknowledge, read data, address acknowledge, reset acknowledge or bus error. The response side has no backpressure, so the consumer must take every word in the cycle it appears.

Top module: `cmdbus_master`

## Requirements
- R1: While reset is high and in the cycle after it, bus_cyc, bus_stb, cmd_busy and rsp_valid are all low.
- R2: A command is taken only in a cycle where cmd_valid is high and cmd_busy is low. cmd_busy is high whenever bus_cyc is high. A read, write or set-address word offered while busy has no effect. The only exception is the bus reset in R9.
- R3: A taken read (cmd_word[33:32]=00) or write (01) raises bus_cyc and bus_stb on the next edge. bus_stb stays high while bus_stall is high. After the slave accepts the request, bus_stb is low and bus_cyc stays high until an acknowledge or error. bus_cyc is low again after every access, before the next one starts.
- R4: An acknowledge that arrives in the same cycle in which the slave accepts the request (bus_stb high, bus_stall low) ends the cycle on that edge. The response is valid two clock edges after the command edge.
- R5: A read returns a response with bits 33:32 = 01 and bits 31:0 equal to bus_rdata sampled with the acknowledge. During the access, bus_we is low.
- R6: A write drives bus_we high and bus_wdata equal to the command payload. It returns a response with bits 33:32 = 00 and a payload of 1.
- R7: A set-address word (bits 33:32 = 10) loads the address from payload bits 29:0. If payload bit 31 is 1, the offset is instead added to the current address, modulo 2^30. The response has bits 33:32 = 10 and a payload of two zero bits followed by the new 30-bit address.
- R8: Payload bit 30 of a set-address word enables auto-increment. The address then rises by one after each request the slave accepts, including one later ended by an error. A request abandoned before acceptance leaves the address unchanged.
- R9: A bus-reset word (bits 33:32 = 11, payload bits 31:28 = 0, other bits ignored) is taken even while busy. bus_cyc and bus_stb are low on the next edge, and the response is 11 with an all-zero payload.
- R10: bus_err during an open cycle ends it on that edge. The response has bits 33:32 = 11 and payload bits 31:29 = 001, with the other bits zero.
- R11: A word with bits 33:32 = 11 and nonzero payload bits 31:28 produces no response and no bus cycle.
- R12: rsp_valid is a one-cycle pulse, one per event. An acknowledge or error seen while bus_cyc is low produces nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word present |
| cmd_word | input | 34 | Type in 33:32, payload in 31:0 |
| cmd_busy | output | 1 | Command not taken (except bus reset) |
| rsp_valid | output | 1 | Response word valid this cycle |
| rsp_word | output | 34 | Response type in 33:32, payload in 31:0 |
| bus_cyc | output | 1 | Wishbone cycle |
| bus_stb | output | 1 | Wishbone strobe |
| bus_we | output | 1 | Write enable |
| bus_addr | output | 30 | Word address |
| bus_wdata | output | 32 | Write data |
| bus_stall | input | 1 | Slave stall |
| bus_ack | input | 1 | Slave acknowledge |
| bus_rdata | input | 32 | Read data |
| bus_err | input | 1 | Slave error |

## Verification
A slave model with random stall counts and random acknowledge delays runs a long random mix of reads, writes and absolute or relative address loads, with auto-increment turned on and off. Its read data is a function of the address it sampled. This setup tells a wrong address or a missed or extra increment apart from a wrong data path. Occasional errors check that an error response replaces the acknowledge. A zero-delay, zero-stall run isolates the same-edge acknowledge path by its exact latency. Resets sent during a long stall and during a long acknowledge wait show the difference between an abandoned unaccepted request, which gives no increment, and an abandoned accepted one. Stray reserved codes, acknowledges while idle and commands offered while busy must leave both ports quiet.

// File: rtl/cmdbus_pkg.sv
`timescale 1ns/1ps
package cmdbus_pkg;
  localparam int TAG_W = 2;
  localparam int CTL_W = 4;

  typedef enum logic [1:0] {
    CMD_RD   = 2'b00,
    CMD_WR   = 2'b01,
    CMD_ADDR = 2'b10,
    CMD_SYS  = 2'b11
  } cmd_kind_e;

  typedef enum logic [1:0] {
    RSP_WACK  = 2'b00,
    RSP_RDATA = 2'b01,
    RSP_AACK  = 2'b10,
    RSP_SYS   = 2'b11
  } rsp_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_REQ  = 2'b01,
    ST_WAIT = 2'b10
  } bus_state_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic set_addr;
    logic bus_rst;
  } cmd_take_t;
endpackage

// File: rtl/cmdbus_decode.sv
`timescale 1ns/1ps
module cmdbus_decode
  import cmdbus_pkg::*;
(
  input  logic             valid,
  input  logic             busy,
  input  logic [TAG_W-1:0] kind,
  input  logic [CTL_W-1:0] ctl,
  output cmd_take_t        take
);
  cmd_kind_e k;
  logic      normal;

  assign k      = cmd_kind_e'(kind);
  assign normal = valid && !busy;

  always_comb begin
    take          = '0;
    take.rd       = normal && (k == CMD_RD);
    take.wr       = normal && (k == CMD_WR);
    take.set_addr = normal && (k == CMD_ADDR);
    take.bus_rst  = valid && (k == CMD_SYS) && (ctl == '0);
  end
endmodule

// File: rtl/cmdbus_fsm.sv
`timescale 1ns/1ps
module cmdbus_fsm
  import cmdbus_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic abort,
  input  logic stall,
  input  logic ack,
  input  logic err,
  output logic cyc,
  output logic stb,
  output logic issued,
  output logic ack_hit,
  output logic err_hit
);
  bus_state_e st, st_nx;

  assign cyc     = (st != ST_IDLE);
  assign stb     = (st == ST_REQ);
  assign issued  = stb && !stall;
  assign ack_hit = cyc && ack && !(stb && stall) && !abort;
  assign err_hit = cyc && err && !abort;

  always_comb begin
    st_nx = st;
    if (abort) begin
      st_nx = ST_IDLE;
    end else begin
      case (st)
        ST_IDLE: if (start) st_nx = ST_REQ;
        ST_REQ: begin
          if (err)         st_nx = ST_IDLE;
          else if (!stall) st_nx = ack ? ST_IDLE : ST_WAIT;
        end
        ST_WAIT: if (err || ack) st_nx = ST_IDLE;
        default: st_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= st_nx;
  end
endmodule

// File: rtl/cmdbus_addr.sv
`timescale 1ns/1ps
module cmdbus_addr #(
  parameter int ADDR_W = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set,
  input  logic              rel,
  input  logic              inc,
  input  logic [ADDR_W-1:0] value,
  input  logic              issued,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] addr_new
);
  logic step_en;

  assign addr_new = rel ? (addr + value) : value;

  // Address needs no reset value; only the step flag does.
  always_ff @(posedge clk) begin
    if (set)                   addr <= addr_new;
    else if (issued && step_en) addr <= addr + ADDR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)      step_en <= 1'b0;
    else if (set) step_en <= inc;
  end
endmodule

// File: rtl/cmdbus_rsp.sv
`timescale 1ns/1ps
module cmdbus_rsp
  import cmdbus_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 30,
  localparam int RSP_W = DATA_W + TAG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rst,
  input  logic              err_hit,
  input  logic              ack_hit,
  input  logic              set_addr,
  input  logic              we,
  input  logic [DATA_W-1:0] rdata,
  input  logic [ADDR_W-1:0] addr_new,
  output logic              valid,
  output logic [RSP_W-1:0]  word
);
  localparam logic [DATA_W-1:0] PL_RST = '0;
  localparam logic [DATA_W-1:0] PL_ERR = {3'b001, {(DATA_W-3){1'b0}}};
  localparam logic [DATA_W-1:0] PL_ONE = DATA_W'(1);

  always_ff @(posedge clk) begin
    if (rst) valid <= 1'b0;
    else     valid <= bus_rst || err_hit || ack_hit || set_addr;
  end

  always_ff @(posedge clk) begin
    if (bus_rst)      word <= {RSP_SYS, PL_RST};
    else if (err_hit) word <= {RSP_SYS, PL_ERR};
    else if (ack_hit) word <= we ? {RSP_WACK, PL_ONE} : {RSP_RDATA, rdata};
    else if (set_addr)
      word <= {RSP_AACK, {(DATA_W-ADDR_W){1'b0}}, addr_new};
  end
endmodule

// File: rtl/cmdbus_master.sv
`timescale 1ns/1ps
module cmdbus_master
  import cmdbus_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 30,
  localparam int CMD_W = DATA_W + TAG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_word,
  output logic              cmd_busy,
  output logic              rsp_valid,
  output logic [CMD_W-1:0]  rsp_word,
  output logic              bus_cyc,
  output logic              bus_stb,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_stall,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_err
);
  cmd_take_t         take;
  logic              issued, ack_hit, err_hit;
  logic [ADDR_W-1:0] addr_new;

  assign cmd_busy = bus_cyc;

  cmdbus_decode u_dec (
    .valid (cmd_valid),
    .busy  (bus_cyc),
    .kind  (cmd_word[CMD_W-1 -: TAG_W]),
    .ctl   (cmd_word[DATA_W-1 -: CTL_W]),
    .take  (take)
  );

  cmdbus_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .start   (take.rd || take.wr),
    .abort   (take.bus_rst),
    .stall   (bus_stall),
    .ack     (bus_ack),
    .err     (bus_err),
    .cyc     (bus_cyc),
    .stb     (bus_stb),
    .issued  (issued),
    .ack_hit (ack_hit),
    .err_hit (err_hit)
  );

  cmdbus_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk      (clk),
    .rst      (rst),
    .set      (take.set_addr),
    .rel      (cmd_word[DATA_W-1]),
    .inc      (cmd_word[DATA_W-2]),
    .value    (cmd_word[ADDR_W-1:0]),
    .issued   (issued),
    .addr     (bus_addr),
    .addr_new (addr_new)
  );

  // Direction and write data load on any accepted access; data unused on reads.
  always_ff @(posedge clk) begin
    if (take.rd || take.wr) begin
      bus_we    <= take.wr;
      bus_wdata <= cmd_word[DATA_W-1:0];
    end
  end

  cmdbus_rsp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rsp (
    .clk      (clk),
    .rst      (rst),
    .bus_rst  (take.bus_rst),
    .err_hit  (err_hit),
    .ack_hit  (ack_hit),
    .set_addr (take.set_addr),
    .we       (bus_we),
    .rdata    (bus_rdata),
    .addr_new (addr_new),
    .valid    (rsp_valid),
    .word     (rsp_word)
  );
endmodule

// File: rtl/cmdbus_master_chk.sv
`timescale 1ns/1ps
module cmdbus_master_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic [5:0] cmd_top,
  input logic       cmd_busy,
  input logic       rsp_valid,
  input logic [4:0] rsp_top,
  input logic       bus_cyc,
  input logic       bus_stb,
  input logic       bus_stall,
  input logic       bus_ack,
  input logic       bus_err
);
  logic rst_cmd;
  assign rst_cmd = cmd_valid && (cmd_top == 6'b110000);

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!bus_cyc && !bus_stb && !rsp_valid && !cmd_busy));

  a_r3_stb_in_cyc: assert property (@(posedge clk) disable iff (rst)
    bus_stb |-> bus_cyc);

  a_r2_start_needs_take: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_stb) |-> $past(cmd_valid && !cmd_busy));

  a_r3_stb_held_on_stall: assert property (@(posedge clk) disable iff (rst)
    (bus_stb && bus_stall && !bus_err && !rst_cmd) |=> bus_stb);

  a_r4_same_edge_ack: assert property (@(posedge clk) disable iff (rst)
    (bus_stb && !bus_stall && bus_ack && !bus_err && !rst_cmd)
      |=> (!bus_cyc && rsp_valid && (rsp_top[4:3] != 2'b11)));

  a_r9_reset_abandons: assert property (@(posedge clk) disable iff (rst)
    rst_cmd |=> (!bus_cyc && !bus_stb && rsp_valid && rsp_top == 5'b11000));

  a_r10_err_abandons: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && bus_err && !rst_cmd) |=> (!bus_cyc && rsp_valid && rsp_top == 5'b11001));

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!bus_cyc && !cmd_valid) |=> !rsp_valid);
endmodule

bind cmdbus_master cmdbus_master_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_top   (cmd_word[CMD_W-1 -: 6]),
  .cmd_busy  (cmd_busy),
  .rsp_valid (rsp_valid),
  .rsp_top   (rsp_word[CMD_W-1 -: 5]),
  .bus_cyc   (bus_cyc),
  .bus_stb   (bus_stb),
  .bus_stall (bus_stall),
  .bus_ack   (bus_ack),
  .bus_err   (bus_err)
);

// File: tb/cmdbus_master_test.sv
`timescale 1ns/1ps
module cmdbus_master_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [33:0] cmd_word = '0;
  logic        cmd_busy, rsp_valid, bus_cyc, bus_stb, bus_we;
  logic [33:0] rsp_word;
  logic [29:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_stall = 1'b0, bus_ack = 1'b0, bus_err = 1'b0;

  cmdbus_master uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .cmd_busy(cmd_busy), .rsp_valid(rsp_valid), .rsp_word(rsp_word),
    .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_stall(bus_stall), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .bus_err(bus_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;

  // slave model controls and observations
  bit hang = 0, stall_hold = 0, no_stall = 0, zero_dly = 0, err_next = 0, inj_ack = 0;
  bit fresh = 1, pend = 0, answered = 0;
  int stall_left = 0, dly = 0, viol = 0;
  logic [29:0] acc_addr = '0;
  logic [31:0] acc_wd = '0;
  bit acc_we = 0;

  // response monitor
  int rsp_cnt = 0;
  logic [33:0] rsp_last = '0;

  // expected model
  logic [29:0] exp_addr = '0;
  bit exp_inc = 0;

  function automatic logic [31:0] rd_pattern(input logic [29:0] a);
    return {a, 2'b01} ^ 32'h5A0F_C3E1;
  endfunction

  function automatic logic [29:0] next_addr(input logic [29:0] cur, input logic [31:0] p);
    return p[31] ? (cur + p[29:0]) : p[29:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (rsp_valid) begin
        rsp_cnt++;
        rsp_last = rsp_word;
      end
    end
  end

  initial begin : slave
    bit a_v, e_v, s_v;
    forever begin
      @(negedge clk);
      a_v = 0; e_v = 0; s_v = 0;
      if (rst || !bus_cyc) begin
        fresh = 1; pend = 0; answered = 0;
        s_v = $urandom % 2;
      end else if (answered) begin
        viol++;
      end else if (bus_stb && !pend) begin
        if (fresh) begin
          stall_left = stall_hold ? 1000000 : (no_stall ? 0 : int'($urandom % 3));
          fresh = 0;
        end
        if (stall_left > 0) begin
          s_v = 1; stall_left--;
        end else begin
          pend = 1;
          acc_addr = bus_addr; acc_we = bus_we; acc_wd = bus_wdata;
          dly = hang ? 1000000 : (zero_dly ? 0 : int'($urandom % 3));
          if (dly == 0) begin
            if (err_next) e_v = 1; else a_v = 1;
            answered = 1;
          end
        end
      end else if (pend) begin
        dly--;
        if (dly <= 0) begin
          if (err_next) e_v = 1; else a_v = 1;
          answered = 1;
        end
      end else begin
        viol++;
      end
      bus_stall = s_v;
      bus_ack   = a_v | inj_ack;
      bus_err   = e_v;
      bus_rdata = rd_pattern(acc_addr);
    end
  end

  // one-cycle drive, ignoring busy; starts and ends just after a falling edge
  task automatic drive_one(input logic [33:0] w);
    cmd_valid = 1; cmd_word = w;
    @(negedge clk); #1;
    cmd_valid = 0;
  endtask

  task automatic run_cmd(input logic [33:0] w, output bit got, output logic [33:0] r, output int lat);
    int base;
    while (cmd_busy) begin @(negedge clk); #1; end
    base = rsp_cnt;
    cmd_valid = 1; cmd_word = w; lat = 0;
    do begin
      @(negedge clk); #1;
      cmd_valid = 0;
      lat++;
    end while (rsp_cnt == base && lat < 300);
    got = (rsp_cnt == base + 1);
    r = rsp_last;
  endtask

  task automatic do_access(input bit wr, input logic [31:0] d, input bit with_err);
    bit got; logic [33:0] r, e; int lat;
    err_next = with_err;
    run_cmd({1'b0, wr, d}, got, r, lat);
    err_next = 0;
    if (with_err) e = {2'b11, 3'b001, 29'h0};
    else if (wr) e = {2'b00, 32'd1};
    else e = {2'b01, rd_pattern(exp_addr)};
    chk(got && r == e, with_err ? "R10 error response" : (wr ? "R6 write ack" : "R5 read data"), r, e);
    chk(acc_addr == exp_addr, "R8 access address", {4'h0, acc_addr}, {4'h0, exp_addr});
    chk(acc_we == wr, "R5/R6 direction", {33'h0, acc_we}, {33'h0, wr});
    if (wr) chk(acc_wd == d, "R6 write data", {2'b0, acc_wd}, {2'b0, d});
    chk(!bus_cyc && !bus_stb, "R3 cycle dropped", {32'h0, bus_cyc, bus_stb}, '0);
    if (exp_inc) exp_addr = exp_addr + 30'd1;
  endtask

  task automatic do_setaddr(input logic [31:0] p);
    bit got; logic [33:0] r, e; int lat;
    run_cmd({2'b10, p}, got, r, lat);
    exp_addr = next_addr(exp_addr, p);
    exp_inc = p[30];
    e = {2'b10, 2'b00, exp_addr};
    chk(got && r == e && lat == 1, "R7 address ack", r, e);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin : main
    bit got; logic [33:0] r; int lat, base;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    #1;
    chk(!bus_cyc && !bus_stb && !rsp_valid && !cmd_busy, "R1 reset state",
        {30'h0, bus_cyc, bus_stb, rsp_valid, cmd_busy}, '0);
    rst = 0;
    @(negedge clk); #1;
    chk(!bus_cyc && !rsp_valid, "R1 after reset", {32'h0, bus_cyc, rsp_valid}, '0);

    // absolute then relative addressing with wrap (R7)
    do_setaddr(32'h3FFF_FFFE);
    do_setaddr(32'h8000_0003);
    do_access(0, 32'h0, 0);
    do_access(1, 32'hCAFE_0001, 0);

    // same-edge acknowledge latency (R4)
    no_stall = 1; zero_dly = 1;
    run_cmd({2'b00, 32'h0}, got, r, lat);
    chk(got && lat == 2, "R4 same-edge ack latency", {2'b0, 32'(lat)}, 34'd2);
    chk(r == {2'b01, rd_pattern(exp_addr)}, "R4 same-edge read data", r, {2'b01, rd_pattern(exp_addr)});
    do_access(1, 32'h1234_5678, 0);
    do_access(0, 32'h0, 1);
    no_stall = 0; zero_dly = 0;

    // reset while idle (R9)
    run_cmd(34'h3_0ABC_DEF0, got, r, lat);
    chk(got && r == {2'b11, 32'h0} && lat == 1, "R9 idle reset ack", r, {2'b11, 32'h0});

    // reserved system code ignored (R11)
    base = rsp_cnt;
    drive_one(34'h3_5000_0000);
    repeat (3) begin @(negedge clk); #1; end
    chk(rsp_cnt == base && !bus_cyc, "R11 reserved code ignored", {2'b0, 32'(rsp_cnt - base)}, '0);

    // stray acknowledge while idle (R12)
    inj_ack = 1; @(negedge clk); #1; inj_ack = 0;
    repeat (2) begin @(negedge clk); #1; end
    chk(rsp_cnt == base && !bus_cyc, "R12 idle ack ignored", {2'b0, 32'(rsp_cnt - base)}, '0);

    // reset during a long acknowledge wait, with a command offered while busy (R2, R9)
    do_setaddr(32'h0000_0100);
    hang = 1;
    drive_one({2'b00, 32'h0});
    repeat (4) begin @(negedge clk); #1; end
    chk(bus_cyc && cmd_busy && !bus_stb, "R2 busy during wait", {31'h0, bus_cyc, cmd_busy, bus_stb}, 34'b110);
    base = rsp_cnt;
    drive_one({2'b01, 32'hDEAD_BEEF});
    chk(rsp_cnt == base && !bus_we, "R2 command while busy ignored", {32'h0, bus_we, 1'b0}, '0);
    drive_one(34'h3_0000_0007);
    chk(rsp_cnt == base + 1 && rsp_last == {2'b11, 32'h0}, "R9 mid-cycle reset ack", rsp_last, {2'b11, 32'h0});
    chk(!bus_cyc && !bus_stb, "R9 cycle abandoned", {32'h0, bus_cyc, bus_stb}, '0);
    hang = 0;
    repeat (4) begin @(negedge clk); #1; end
    chk(!bus_cyc && rsp_cnt == base + 1, "R2 no late start", {33'h0, bus_cyc}, '0);
    do_access(0, 32'h0, 0);

    // reset while stalled, auto-increment on: no step for unaccepted request (R8)
    do_setaddr(32'h4000_0200);
    stall_hold = 1;
    drive_one({2'b00, 32'h0});
    repeat (3) begin @(negedge clk); #1; end
    chk(bus_stb && bus_cyc, "R3 strobe held while stalled", {32'h0, bus_stb, bus_cyc}, 34'b11);
    base = rsp_cnt;
    drive_one(34'h3_0000_0000);
    chk(rsp_cnt == base + 1 && !bus_cyc, "R9 reset during stall", rsp_last, {2'b11, 32'h0});
    stall_hold = 0;
    do_access(0, 32'h0, 0);
    do_access(1, 32'h0BAD_F00D, 0);
    chk(exp_addr == 30'h202, "R8 two steps", {4'h0, exp_addr}, 34'h202);

    // random mix
    for (int i = 0; i < 300; i++) begin
      int pick = $urandom % 8;
      if (pick < 3) do_access(0, $urandom, ($urandom % 10) == 0);
      else if (pick < 6) do_access(1, $urandom, ($urandom % 10) == 0);
      else do_setaddr({1'($urandom), 1'($urandom), $urandom} & 32'hC000_FFFF);
    end

    chk(viol == 0, "R3 protocol order", {2'b0, 32'(viol)}, '0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule